// File: doc/BRIEF.md
# Multithreaded Warp Issue Scheduler

This block holds the residency and readiness state of up to 48 warps living on one SIMT core. A warp is a group of 32 threads that run the same instruction together. In every cycle where the shared lane array can take an instruction, the scheduler names one ready warp whose next instruction goes out. A warp that begins a long-latency operation, such as a memory access, is marked stalled and is passed over until a completion event for it comes back. Every warp owns a private register context, so moving from one warp to another costs no cycle. The choice among warps comes from their stall and wake state, not from fixed time slices.

Work enters through a launch request, which claims a free warp slot. A retire event frees a slot again. Stall and wake events come from the abstract issue and completion handshakes of the datapath, which lies outside the block. The scheduler only reports which warp issues and whether an issue happens. It sees neither instruction fetch nor decode.

Top module: `warp_sched`

## Requirements
- R1: After reset, no slot is resident and `issue_vld` is 0 even with `issue_en` high. The first launch then receives slot 0.
- R2: A launch request that is not refused claims the lowest-numbered free slot, which is reported on `launch_id` in the same cycle. That warp is resident and ready from the next cycle on.
- R3: While all 48 slots are resident, a launch request drives `launch_busy` high and changes no slot. `launch_busy` is low whenever `launch_req` is low.
- R4: `issue_vld` is 1 exactly when `issue_en` is 1 and at least one eligible warp exists. An eligible warp is resident, not stalled and not retiring this cycle. When `issue_vld` is 1, `issue_id` names an eligible warp.
- R5: The issued warp is the first eligible slot found by counting upward from the slot issued most recently, wrapping from 47 to 0. Right after reset, the search starts at slot 0.
- R6: A stall event marks its warp as not eligible from the next cycle. The warp stays that way until a wake event for it arrives, and it is eligible again in the cycle after the wake.
- R7: A stall and a wake for the same warp in the same cycle leave that warp ready.
- R8: A retiring slot is never issued in its retire cycle. From the next cycle on it is free, and it is handed out again by a later launch.
- R9: When several warps are ready, a different warp can be issued on every consecutive cycle, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. It is released synchronously inside the block. |
| launch_req | input | 1 | Request to place a new warp in a free slot |
| launch_busy | output | 1 | The launch request is refused because every slot is occupied |
| launch_id | output | 6 | Slot granted to the launch in this cycle |
| retire_vld | input | 1 | A warp finishes and its slot is released |
| retire_id | input | 6 | Slot being retired |
| stall_vld | input | 1 | A warp began a long-latency operation |
| stall_id | input | 6 | Warp that stalls |
| wake_vld | input | 1 | A long-latency operation completed |
| wake_id | input | 6 | Warp whose operation completed |
| issue_en | input | 1 | The lane array can accept an instruction this cycle |
| issue_vld | output | 1 | An instruction is issued this cycle |
| issue_id | output | 6 | Warp whose instruction is issued |

## Verification
Two pairs of functions can land in the same cycle. In the first, a stall and a wake hit one warp together. The bench provokes this on a resident warp and judges it by whether that warp comes back in the round-robin order on the next cycles. In the second, a retire hits the very slot that round-robin would pick next. The bench judges that cycle directly: the retiring slot must not be issued, and the next eligible warp must be issued in its place.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
  localparam int DEFAULT_WARPS      = 48;
  localparam int THREADS_PER_WARP   = 32;
  localparam int RST_SYNC_STAGES    = 2;
endpackage

// File: rtl/ws_slot_table.sv
module ws_slot_table #(
  parameter int NUM_WARPS = 48,
  localparam int ID_W = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch_fire,
  input  logic [ID_W-1:0]      launch_slot,
  input  logic                 retire_vld,
  input  logic [ID_W-1:0]      retire_id,
  input  logic                 stall_vld,
  input  logic [ID_W-1:0]      stall_id,
  input  logic                 wake_vld,
  input  logic [ID_W-1:0]      wake_id,
  output logic [NUM_WARPS-1:0] resident,
  output logic [NUM_WARPS-1:0] stalled
);

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_slot
    logic res_q, res_d, stl_q, stl_d, upd;
    logic hit_l, hit_r, hit_s, hit_w;

    always_comb begin
      hit_l = launch_fire && (launch_slot == ID_W'(g));
      hit_r = retire_vld  && (retire_id   == ID_W'(g));
      hit_s = stall_vld   && (stall_id    == ID_W'(g));
      hit_w = wake_vld    && (wake_id     == ID_W'(g));
      upd   = hit_l | hit_r | hit_s | hit_w;
      res_d = res_q;
      stl_d = stl_q;
      if (hit_l) begin
        res_d = 1'b1;
        stl_d = 1'b0;
      end else if (hit_r) begin
        res_d = 1'b0;
        stl_d = 1'b0;
      end else begin
        // stall applied first, then a wake in the same cycle clears it
        stl_d = (stl_q | hit_s) & ~hit_w;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q <= 1'b0;
        stl_q <= 1'b0;
      end else if (upd) begin
        res_q <= res_d;
        stl_q <= stl_d;
      end
    end

    assign resident[g] = res_q;
    assign stalled[g]  = stl_q;
  end

endmodule

// File: rtl/ws_free_finder.sv
module ws_free_finder #(
  parameter int NUM_WARPS = 48,
  localparam int ID_W = $clog2(NUM_WARPS)
) (
  input  logic [NUM_WARPS-1:0] resident,
  output logic [ID_W-1:0]      free_id,
  output logic                 all_full
);

  always_comb begin
    free_id = '0;
    for (int i = NUM_WARPS - 1; i >= 0; i--) begin
      if (!resident[i]) free_id = ID_W'(i);
    end
    all_full = &resident;
  end

endmodule

// File: rtl/ws_rr_picker.sv
module ws_rr_picker #(
  parameter int NUM_WARPS = 48,
  localparam int ID_W = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] eligible,
  input  logic                 accept,
  output logic                 any_ready,
  output logic [ID_W-1:0]      pick_id
);

  logic [ID_W-1:0] last_q, last_d;
  logic            last_en;

  always_comb begin
    int idx;
    any_ready = 1'b0;
    pick_id   = '0;
    idx       = 0;
    for (int k = 1; k <= NUM_WARPS; k++) begin
      idx = (int'(last_q) + k) % NUM_WARPS;
      if (!any_ready && eligible[idx]) begin
        any_ready = 1'b1;
        pick_id   = ID_W'(idx);
      end
    end
    last_en = accept && any_ready;
    last_d  = pick_id;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= ID_W'(NUM_WARPS - 1);
    else if (last_en) last_q <= last_d;
  end

endmodule

// File: rtl/warp_sched.sv
module warp_sched
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = DEFAULT_WARPS,
  localparam int ID_W = $clog2(NUM_WARPS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch_req,
  output logic            launch_busy,
  output logic [ID_W-1:0] launch_id,
  input  logic            retire_vld,
  input  logic [ID_W-1:0] retire_id,
  input  logic            stall_vld,
  input  logic [ID_W-1:0] stall_id,
  input  logic            wake_vld,
  input  logic [ID_W-1:0] wake_id,
  input  logic            issue_en,
  output logic            issue_vld,
  output logic [ID_W-1:0] issue_id
);

  logic [RST_SYNC_STAGES-1:0] rst_sync_q;
  logic                       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RST_SYNC_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[RST_SYNC_STAGES-1];

  logic [NUM_WARPS-1:0] resident, stalled, retire_mask, eligible;
  logic [ID_W-1:0]      free_id, pick_id;
  logic                 all_full, launch_fire, any_ready;

  ws_free_finder #(.NUM_WARPS(NUM_WARPS)) u_free (
    .resident (resident),
    .free_id  (free_id),
    .all_full (all_full)
  );

  assign launch_fire = launch_req & ~all_full;
  assign launch_busy = launch_req & all_full;
  assign launch_id   = free_id;

  ws_slot_table #(.NUM_WARPS(NUM_WARPS)) u_table (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .launch_fire (launch_fire),
    .launch_slot (free_id),
    .retire_vld  (retire_vld),
    .retire_id   (retire_id),
    .stall_vld   (stall_vld),
    .stall_id    (stall_id),
    .wake_vld    (wake_vld),
    .wake_id     (wake_id),
    .resident    (resident),
    .stalled     (stalled)
  );

  always_comb begin
    retire_mask = '0;
    if (retire_vld) retire_mask[retire_id] = 1'b1;
    eligible = resident & ~stalled & ~retire_mask;
  end

  ws_rr_picker #(.NUM_WARPS(NUM_WARPS)) u_pick (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .eligible  (eligible),
    .accept    (issue_en),
    .any_ready (any_ready),
    .pick_id   (pick_id)
  );

  assign issue_vld = issue_en & any_ready;
  assign issue_id  = pick_id;

endmodule

// File: rtl/warp_sched_chk.sv
module warp_sched_chk #(
  parameter int NUM_WARPS = 48,
  localparam int ID_W = $clog2(NUM_WARPS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            launch_req,
  input logic            launch_busy,
  input logic [ID_W-1:0] launch_id,
  input logic            retire_vld,
  input logic [ID_W-1:0] retire_id,
  input logic            stall_vld,
  input logic [ID_W-1:0] stall_id,
  input logic            wake_vld,
  input logic [ID_W-1:0] wake_id,
  input logic            issue_en,
  input logic            issue_vld,
  input logic [ID_W-1:0] issue_id
);

  a_r3_busy_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    launch_busy |-> launch_req);

  a_r4_issue_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> issue_en);

  a_r4_issue_id_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> (int'(issue_id) < NUM_WARPS));

  a_r2_launch_id_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_req && !launch_busy) |-> (int'(launch_id) < NUM_WARPS));

  a_r8_no_issue_of_retiring: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && retire_vld) |-> (issue_id != retire_id));

  a_r6_stalled_skipped: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_vld && !(wake_vld && wake_id == stall_id)
      && !(launch_req && !launch_busy && launch_id == stall_id))
    |=> !(issue_vld && issue_id == $past(stall_id)));

endmodule

bind warp_sched warp_sched_chk #(.NUM_WARPS(NUM_WARPS)) u_chk (.*);

// File: tb/sim_warp_sched.sv
`timescale 1ns/1ps
module sim_warp_sched;
  localparam int NW = 48;
  localparam int IW = $clog2(NW);

  logic clk = 1'b0;
  logic rst_n;
  logic launch_req, launch_busy, retire_vld, stall_vld, wake_vld, issue_en, issue_vld;
  logic [IW-1:0] launch_id, retire_id, stall_id, wake_id, issue_id;

  int n_chk = 0;
  int n_fail = 0;
  bit m_res [NW];
  bit m_stl [NW];
  int m_last;

  always #10 clk = ~clk;

  warp_sched #(.NUM_WARPS(NW)) u0 (.*);

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // drive one cycle of stimulus, compare outputs with the requirement model, advance the model
  task automatic cyc(string tag, bit lr, bit sv, int si, bit wv, int wi,
                     bit rv, int ri, bit en);
    bit full, ev;
    int lid, eid;
    @(negedge clk);
    launch_req = lr; stall_vld = sv; stall_id = IW'(si);
    wake_vld = wv; wake_id = IW'(wi); retire_vld = rv; retire_id = IW'(ri);
    issue_en = en;
    #2;
    full = 1'b1; lid = 0;
    for (int i = NW - 1; i >= 0; i--) if (!m_res[i]) begin full = 1'b0; lid = i; end
    ev = 1'b0; eid = 0;
    for (int k = 1; k <= NW; k++) begin
      int j = (m_last + k) % NW;
      if (!ev && m_res[j] && !m_stl[j] && !(rv && j == ri)) begin ev = 1'b1; eid = j; end
    end
    ev = ev && en;
    chk(tag, "issue_vld", int'(issue_vld), int'(ev));
    if (ev) chk(tag, "issue_id", int'(issue_id), eid);
    chk(tag, "launch_busy", int'(launch_busy), int'(lr && full));
    if (lr && !full) chk(tag, "launch_id", int'(launch_id), lid);
    @(posedge clk);
    if (ev) m_last = eid;
    if (sv) m_stl[si] = 1'b1;
    if (wv) m_stl[wi] = 1'b0;
    if (rv) begin m_res[ri] = 1'b0; m_stl[ri] = 1'b0; end
    if (lr && !full) begin m_res[lid] = 1'b1; m_stl[lid] = 1'b0; end
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_reset;
    @(negedge clk); issue_en = 1'b1; #2;
    chk("R1", "issue_vld after reset", int'(issue_vld), 0);
    cyc("R1", 1, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_launch_rr;
    cyc("R2", 1, 0, 0, 0, 0, 0, 0, 1);
    cyc("R2", 1, 0, 0, 0, 0, 0, 0, 1);
    idle("R5", 4);
    idle("R9", 3);
  endtask

  task automatic t_stall_wake;
    cyc("R6", 0, 1, 1, 0, 0, 0, 0, 1);
    idle("R6", 4);
    cyc("R6", 0, 0, 0, 1, 1, 0, 0, 1);
    idle("R6", 3);
  endtask

  task automatic t_same_cycle;
    cyc("R7", 0, 1, 2, 1, 2, 0, 0, 1);
    idle("R7", 4);
  endtask

  task automatic t_none_ready;
    cyc("R4", 0, 1, 0, 0, 0, 0, 0, 1);
    cyc("R4", 0, 1, 1, 0, 0, 0, 0, 1);
    cyc("R4", 0, 1, 2, 0, 0, 0, 0, 1);
    idle("R4", 2);
    cyc("R4", 0, 0, 0, 1, 0, 0, 0, 0);
    cyc("R4", 0, 0, 0, 1, 1, 0, 0, 1);
    cyc("R4", 0, 0, 0, 1, 2, 0, 0, 1);
    idle("R4", 3);
  endtask

  task automatic t_retire;
    // pick the slot round-robin would choose next and retire it in that cycle
    int nxt = (m_last + 1) % NW;
    while (!m_res[nxt]) nxt = (nxt + 1) % NW;
    cyc("R8", 0, 0, 0, 0, 0, 1, nxt, 1);
    idle("R8", 3);
    cyc("R8", 1, 0, 0, 0, 0, 0, 0, 1);
    chk("R8", "freed slot reused", int'(launch_id), nxt);
    idle("R8", 2);
  endtask

  task automatic t_full;
    for (int i = 0; i < NW; i++) cyc("R3", 1, 0, 0, 0, 0, 0, 0, 1);
    cyc("R3", 1, 0, 0, 0, 0, 0, 0, 1);
    cyc("R3", 0, 0, 0, 0, 0, 0, 0, 1);
    cyc("R3", 0, 0, 0, 0, 0, 1, 17, 1);
    cyc("R3", 1, 0, 0, 0, 0, 0, 0, 1);
    chk("R3", "slot after refusal", int'(launch_id), 17);
    idle("R9", 60);
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) begin m_res[i] = 1'b0; m_stl[i] = 1'b0; end
    m_last = NW - 1;
    rst_n = 1'b0;
    launch_req = 0; retire_vld = 0; stall_vld = 0; wake_vld = 0; issue_en = 0;
    retire_id = '0; stall_id = '0; wake_id = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset;
    t_launch_rr;
    t_stall_wake;
    t_same_cycle;
    t_none_ready;
    t_retire;
    t_full;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule